// File: doc/BRIEF.md
# Pipelined Integer Divider with Zero Detection

This block divides an n-bit numerator by an n-bit denominator. It returns an n-bit quotient and an n-bit remainder. It uses a chain of restoring shift-subtract iterations. Registers are inserted after every group of `ITERS` iterations, so the pipeline is `DW/ITERS` stages deep. A parameter selects two's-complement or unsigned arithmetic. Signed division truncates toward zero. The remainder follows the numerator's sign.

Operands enter as a stream with a valid marker (`in_valid`) and leave with a matching marker (`out_valid`). There is no ready signal and no back-pressure. A downstream consumer that cannot accept a result must drop the clock enable `en`. While `en` is low, every stage holds its contents, the inputs are not sampled and the outputs do not move. While `en` is high, one operand pair is taken and one slot moves out on every rising edge.

A zero denominator does not stall or trap. The result carries `div_zero`, the numerator comes back as the remainder, and the quotient saturates toward the numerator's sign.

Top module: `pdiv_top`

## Requirements
- R1: With `SIGNED`=0, `quo` is floor(num/den) and `rem` is num mod den, both `DW` bits, for every den not zero.
- R2: With `SIGNED`=1, operands are two's complement and `quo` is num/den truncated toward zero. `rem` equals num − quo×den, and it is either zero or has the sign bit (bit `DW`-1) of num.
- R3: When den is zero, the result has `div_zero`=1 and `rem` equal to num. In every other case `div_zero`=0.
- R4: When den is zero, `quo` saturates. Signed with a negative numerator it is −2^(DW−1). Signed with num ≥ 0 (including 0/0) it is 2^(DW−1)−1. Unsigned it is all ones.
- R5: A pair sampled with `in_valid`=1 on an enabled edge appears at the outputs, with `out_valid`=1, after exactly `DW/ITERS` enabled edges.
- R6: A new pair can be sampled on every enabled edge. Results leave in input order, one per enabled edge.
- R7: On an edge with `en`=0, nothing is sampled and every stage holds. `out_valid`, `quo`, `rem` and `div_zero` keep their values.
- R8: A slot sampled with `in_valid`=0 leaves as a bubble with `out_valid`=0.
- R9: Signed −2^(DW−1) divided by −1 gives quotient −2^(DW−1) and remainder 0, with `div_zero`=0.
- R10: While `rst_n` is low, `out_valid`, `quo`, `rem` and `div_zero` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Clock enable; low stalls the whole pipeline |
| in_valid | input | 1 | Marks `num`/`den` as a real operand pair |
| num | input | DW | Numerator |
| den | input | DW | Denominator |
| out_valid | output | 1 | Marks the current outputs as a real result |
| quo | output | DW | Quotient |
| rem | output | DW | Remainder |
| div_zero | output | 1 | Result came from a zero denominator |

## Verification
The bench builds two instances side by side, driven by the same enable and valid stream:
- A signed one with `DW`=8 and `ITERS`=2, which is four stages deep with two iterations per stage.
- An unsigned one with `DW`=6 and `ITERS`=6, which performs every iteration in a single stage.

Together they cover the deep and the one-stage variants, both arithmetic modes, the most-negative wrap and all three saturation values. They also cover stalls that occur while results are mid-flight at different depths.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;

  // Side-band that travels with each slot through the pipeline
  typedef struct packed {
    logic valid;   // slot holds a real operand pair
    logic neg_q;   // quotient must be negated
    logic neg_r;   // numerator was negative
    logic dz;      // denominator was zero
  } pdiv_tag_t;

endpackage

// File: rtl/pdiv_prep.sv
module pdiv_prep
  import pdiv_pkg::*;
#(
  parameter int DW     = 8,
  parameter bit SIGNED = 1'b1
) (
  input  logic          in_valid,
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  output pdiv_tag_t     tag_o,
  output logic [DW-1:0] num_mag,
  output logic [DW-1:0] den_mag
);

  logic num_neg, den_neg;

  always_comb begin
    num_neg = SIGNED && num[DW-1];
    den_neg = SIGNED && den[DW-1];
    // Two's-complement magnitude; the most negative value maps to 2^(DW-1)
    num_mag = num_neg ? (~num + 1'b1) : num;
    den_mag = den_neg ? (~den + 1'b1) : den;
    tag_o.valid = in_valid;
    tag_o.neg_q = num_neg ^ den_neg;
    tag_o.neg_r = num_neg;
    tag_o.dz    = (den == '0);
  end

endmodule

// File: rtl/pdiv_stage.sv
module pdiv_stage
  import pdiv_pkg::*;
#(
  parameter int DW    = 8,
  parameter int ITERS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  pdiv_tag_t     tag_i,
  input  logic [DW-1:0] rem_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] den_i,
  output pdiv_tag_t     tag_o,
  output logic [DW-1:0] rem_o,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] den_o
);

  logic [DW-1:0] r_n, a_n;
  logic [DW:0]   sh;
  logic [DW+1:0] trial;

  // ITERS restoring steps: the partial remainder picks up the next numerator
  // bit, and the quotient bit shifts into the bottom of the accumulator.
  always_comb begin
    r_n   = rem_i;
    a_n   = acc_i;
    sh    = '0;
    trial = '0;
    for (int k = 0; k < ITERS; k++) begin
      sh    = {r_n, a_n[DW-1]};
      a_n   = {a_n[DW-2:0], 1'b0};
      trial = {1'b0, sh} - {2'b00, den_i};
      if (!trial[DW+1]) begin
        r_n    = trial[DW-1:0];
        a_n[0] = 1'b1;
      end else begin
        r_n = sh[DW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_o <= '0;
      rem_o <= '0;
      acc_o <= '0;
      den_o <= '0;
    end else if (en) begin
      tag_o <= tag_i;
      rem_o <= r_n;
      acc_o <= a_n;
      den_o <= den_i;
    end
  end

  // The stored partial remainder never reaches the divisor magnitude
  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_o.valid && !tag_o.dz) |-> (rem_o < den_o)); // R2

endmodule

// File: rtl/pdiv_fix.sv
module pdiv_fix
  import pdiv_pkg::*;
#(
  parameter int DW     = 8,
  parameter bit SIGNED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pdiv_tag_t     tag_i,
  input  logic [DW-1:0] rem_u,
  input  logic [DW-1:0] quo_u,
  output logic          out_valid,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem,
  output logic          div_zero
);

  localparam logic [DW-1:0] QMAX = SIGNED ? {1'b0, {(DW-1){1'b1}}} : {DW{1'b1}};
  localparam logic [DW-1:0] QMIN = SIGNED ? {1'b1, {(DW-1){1'b0}}} : '0;

  always_comb begin
    out_valid = tag_i.valid;
    div_zero  = tag_i.valid && tag_i.dz;
    rem       = tag_i.neg_r ? (~rem_u + 1'b1) : rem_u;
    if (tag_i.dz)
      quo = tag_i.neg_r ? QMIN : QMAX;
    else
      quo = tag_i.neg_q ? (~quo_u + 1'b1) : quo_u;
  end

  AST_DZ_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |-> (quo == ((SIGNED && rem[DW-1]) ? QMIN : QMAX))); // R4

  AST_REM_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && rem != '0) |-> (rem[DW-1] == (SIGNED ? tag_i.neg_r : rem[DW-1]))); // R2

endmodule

// File: rtl/pdiv_top.sv
module pdiv_top
  import pdiv_pkg::*;
#(
  parameter int DW     = 8,
  parameter int ITERS  = 1,
  parameter bit SIGNED = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_valid,
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          out_valid,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem,
  output logic          div_zero
);

  localparam int NSTG = DW / ITERS;

  pdiv_tag_t     tag_s [NSTG+1];
  logic [DW-1:0] rem_s [NSTG+1];
  logic [DW-1:0] acc_s [NSTG+1];
  logic [DW-1:0] den_s [NSTG+1];

  assign rem_s[0] = '0;

  pdiv_prep #(.DW(DW), .SIGNED(SIGNED)) u_prep (
    .in_valid(in_valid), .num(num), .den(den),
    .tag_o(tag_s[0]), .num_mag(acc_s[0]), .den_mag(den_s[0])
  );

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    pdiv_stage #(.DW(DW), .ITERS(ITERS)) u_stage (
      .clk(clk), .rst_n(rst_n), .en(en),
      .tag_i(tag_s[s]), .rem_i(rem_s[s]), .acc_i(acc_s[s]), .den_i(den_s[s]),
      .tag_o(tag_s[s+1]), .rem_o(rem_s[s+1]), .acc_o(acc_s[s+1]), .den_o(den_s[s+1])
    );
  end

  pdiv_fix #(.DW(DW), .SIGNED(SIGNED)) u_fix (
    .clk(clk), .rst_n(rst_n), .tag_i(tag_s[NSTG]),
    .rem_u(rem_s[NSTG]), .quo_u(acc_s[NSTG]),
    .out_valid(out_valid), .quo(quo), .rem(rem), .div_zero(div_zero)
  );

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(out_valid) && $stable(quo) && $stable(rem) && $stable(div_zero))); // R7

  AST_BUBBLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !div_zero); // R8

endmodule

// File: tb/tb_pdiv_top.sv
module tb_pdiv_top;
  localparam int DW_S = 8, IT_S = 2, LAT_S = DW_S / IT_S;
  localparam int DW_U = 6, IT_U = 6, LAT_U = DW_U / IT_U;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, in_valid = 1'b0;
  logic [DW_S-1:0] num_s = '0, den_s = '0, quo_s, rem_s;
  logic [DW_U-1:0] num_u = '0, den_u = '0, quo_u, rem_u;
  logic ov_s, dz_s, ov_u, dz_u;

  always #5 clk = ~clk;

  pdiv_top #(.DW(DW_S), .ITERS(IT_S), .SIGNED(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .num(num_s), .den(den_s),
    .out_valid(ov_s), .quo(quo_s), .rem(rem_s), .div_zero(dz_s));

  pdiv_top #(.DW(DW_U), .ITERS(IT_U), .SIGNED(1'b0)) dut_u (
    .clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid), .num(num_u), .den(den_u),
    .out_valid(ov_u), .quo(quo_u), .rem(rem_u), .div_zero(dz_u));

  typedef struct { bit v; longint q; longint r; bit dz; string req; } exp_t;
  exp_t ms [LAT_S];
  exp_t mu [LAT_U];
  int checks = 0, fails = 0;
  logic [DW_S-1:0] pq_s, pr_s; logic pv_s, pz_s;
  logic [DW_U-1:0] pq_u, pr_u; logic pv_u, pz_u;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic exp_t mk(bit v, longint a, longint b, int dw, bit sgn);
    exp_t e;
    longint mask = (longint'(1) << dw) - 1;
    longint mn = sgn ? -(longint'(1) << (dw-1)) : 0;
    longint mx = sgn ? (longint'(1) << (dw-1)) - 1 : mask;
    longint q, r;
    e.v = v; e.dz = 1'b0;
    if (b == 0) begin
      e.dz = 1'b1; r = a; q = (a < 0) ? mn : mx; e.req = "R3 R4";
    end else if (sgn && a == mn && b == -1) begin
      q = mn; r = 0; e.req = "R9";
    end else begin
      q = a / b; r = a % b; e.req = sgn ? "R2" : "R1";
    end
    e.q = q & mask; e.r = r & mask;
    return e;
  endfunction

  task automatic snap();
    pq_s = quo_s; pr_s = rem_s; pv_s = ov_s; pz_s = dz_s;
    pq_u = quo_u; pr_u = rem_u; pv_u = ov_u; pz_u = dz_u;
  endtask

  task automatic compare(bit e);
    exp_t xs, xu;
    xs = ms[LAT_S-1]; xu = mu[LAT_U-1];
    chk("R5 R6 R8", "signed out_valid", longint'(ov_s), longint'(xs.v));
    chk("R5 R6 R8", "unsigned out_valid", longint'(ov_u), longint'(xu.v));
    if (xs.v && ov_s) begin
      chk(xs.req, "signed quo", longint'(quo_s), xs.q);
      chk(xs.req, "signed rem", longint'(rem_s), xs.r);
      chk(xs.dz ? "R3" : "R3 no flag", "signed div_zero", longint'(dz_s), longint'(xs.dz));
    end
    if (xu.v && ov_u) begin
      chk(xu.req, "unsigned quo", longint'(quo_u), xu.q);
      chk(xu.req, "unsigned rem", longint'(rem_u), xu.r);
      chk("R3", "unsigned div_zero", longint'(dz_u), longint'(xu.dz));
    end
    if (!e) begin // R7: held edge
      chk("R7", "signed hold", longint'({pv_s, pz_s, pq_s, pr_s}), longint'({ov_s, dz_s, quo_s, rem_s}));
      chk("R7", "unsigned hold", longint'({pv_u, pz_u, pq_u, pr_u}), longint'({ov_u, dz_u, quo_u, rem_u}));
    end
  endtask

  task automatic step(bit e, bit v, longint as, longint bs, longint au, longint bu);
    en = e; in_valid = v;
    num_s = DW_S'(as); den_s = DW_S'(bs);
    num_u = DW_U'(au); den_u = DW_U'(bu);
    if (e) begin
      for (int i = LAT_S-1; i > 0; i--) ms[i] = ms[i-1];
      ms[0] = mk(v, as, bs, DW_S, 1'b1);
      for (int i = LAT_U-1; i > 0; i--) mu[i] = mu[i-1];
      mu[0] = mk(v, au, bu, DW_U, 1'b0);
    end
    @(negedge clk);
    compare(e);
    snap();
  endtask

  function automatic longint sx8(int x);
    return (x >= 128) ? longint'(x - 256) : longint'(x);
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    longint da [12] = '{10, -5, -128, -128, 0, 127, -1, -128, 127, 7, -7, 100};
    longint db [12] = '{-3, 0, -1, 0, 0, 0, 127, 1, -128, 2, 2, -7};
    longint ua [12] = '{63, 0, 63, 5, 60, 1, 0, 33, 62, 17, 9, 63};
    longint ub [12] = '{0, 0, 1, 7, 7, 63, 5, 33, 0, 4, 10, 63};
    for (int i = 0; i < LAT_S; i++) ms[i] = '{0, 0, 0, 0, ""};
    for (int i = 0; i < LAT_U; i++) mu[i] = '{0, 0, 0, 0, ""};
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "reset signed", longint'({ov_s, dz_s, quo_s, rem_s}), 0);
    chk("R10", "reset unsigned", longint'({ov_u, dz_u, quo_u, rem_u}), 0);
    snap();
    rst_n = 1'b1;
    // Directed back-to-back operands (R6), including 10/-3 then -5/0
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, da[i], db[i], ua[i], ub[i]);
    // Stall with live inputs that must be ignored (R7), then a bubble (R8)
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 99, 0, 50, 0);
    step(1'b1, 1'b0, 3, 0, 3, 0);
    for (int i = 0; i < 2; i++) step(1'b0, 1'b0, -1, -1, 1, 1);
    for (int i = 0; i < LAT_S + 2; i++) step(1'b1, 1'b1, 0, 1, 0, 1);
    // Random traffic with stalls, bubbles, zero divisors and the wrap case
    for (int n = 0; n < 4000; n++) begin
      bit e = ($urandom_range(0, 3) != 0);
      bit v = ($urandom_range(0, 4) != 0);
      longint as = sx8($urandom_range(0, 255));
      longint bs = sx8($urandom_range(0, 255));
      longint au = $urandom_range(0, 63);
      longint bu = $urandom_range(0, 63);
      int pick = $urandom_range(0, 11);
      if (pick == 0) begin bs = 0; bu = 0; end
      if (pick == 1) begin as = -128; bs = -1; end
      if (pick == 2) begin bs = sx8($urandom_range(253, 255)); bu = $urandom_range(1, 2); end
      step(e, v, as, bs, au, bu);
    end
    for (int i = 0; i < LAT_S + 1; i++) step(1'b1, 1'b0, 0, 1, 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule